// File: doc/BRIEF.md
# Root Port Error Status Collector

This block sits at a root port and absorbs error messages that arrive from below. Each message carries a severity (correctable, non-fatal or fatal) and a requester source ID. The block keeps the root error status word. It tracks the first and any repeated occurrence of each error class, and it captures the source ID of the first correctable and the first uncorrectable message. Later messages of the same class leave the captured source IDs alone until software clears the matching received bit.

Software programs a three-bit command word that enables each severity class. It clears status bits by writing ones. The block turns the enabled received conditions into an interrupt. In legacy mode this is a level that follows the enabled conditions. In message mode it is a one-cycle pulse that fires only when the set of enabled-and-received conditions goes from empty to non-empty. That change can come from an arriving message or from a command write. The interrupt message number is loaded through a side input and software cannot write it.

Top module: `root_err_collector`

## Requirements
- R1: A correctable message (msgSev code 0) sets rootSts bit 0. If bit 0 was already set, it also sets bit 1 and leaves corSrcId unchanged. Otherwise corSrcId takes msgSrcId.
- R2: A non-fatal message (code 1) sets rootSts bit 5. A fatal message (code 2) sets bit 6, and sets bit 4 only if bit 2 was clear before the message.
- R3: Any non-fatal or fatal message sets rootSts bit 2. If bit 2 was already set, it also sets bit 3 and leaves uncorSrcId unchanged. Otherwise uncorSrcId takes msgSrcId.
- R4: With msiEnable high, a message produces a one-cycle intPulse only if its class is enabled in rootCmd (bit 0 correctable, bit 1 non-fatal, bit 2 fatal) and no enabled class had its received bit set before the message.
- R5: With msiEnable low, intLevel is high exactly when some class has both its rootCmd bit and its received bit set. The received bits are 0, 5 and 6. intLevel follows command writes. With msiEnable high, intLevel stays low.
- R6: With msiEnable high, a command write produces intPulse only if it makes an enabled condition true when none was true under the old command.
- R7: Writing stsClrData with stsClrEn high clears every rootSts bit that has a one in the written data. Other bits are left as they are.
- R8: intVector loads vecIn only when vecLoad is high. Status clears and command writes do not change it.
- R9: Reset clears rootCmd, rootSts, both source IDs, intVector and intPulse to zero.
- R10: All outputs except intLevel update on the clock edge that samples the message or write. When a status clear and a message fall in the same cycle, the clear applies first. The message then sets its bits and captures IDs as if the cleared bits were zero.
- R11: A message with the reserved severity code 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| msgValid | input | 1 | Error message present this cycle |
| msgSev | input | 2 | Severity: 0 correctable, 1 non-fatal, 2 fatal, 3 reserved |
| msgSrcId | input | SRC_W | Requester ID of the message |
| cmdWrEn | input | 1 | Software command write strobe |
| cmdWrData | input | 3 | New command enables {fatal, non-fatal, correctable} |
| stsClrEn | input | 1 | Software status write strobe |
| stsClrData | input | 7 | Write-one-to-clear mask for rootSts |
| msiEnable | input | 1 | Message-interrupt mode selected |
| vecLoad | input | 1 | Load strobe for the interrupt message number |
| vecIn | input | VEC_W | Interrupt message number to load |
| rootCmd | output | 3 | Command enables |
| rootSts | output | 7 | Status word |
| corSrcId | output | SRC_W | Source of first correctable message |
| uncorSrcId | output | SRC_W | Source of first uncorrectable message |
| intVector | output | VEC_W | Interrupt message number |
| intLevel | output | 1 | Legacy interrupt level |
| intPulse | output | 1 | One-cycle message interrupt |

## Verification
The bench builds the block with its default parameters: a 16-bit source ID and a 5-bit message number. With these, distinct full-width IDs show which message was captured and which was ignored. The stimulus runs first in legacy mode and then in message mode over the same status word. It reaches the repeat-message paths, a first fatal after a non-fatal, enable transitions caused only by command writes, and a clear that coincides with a message.

// File: rtl/rootErrPkg.sv
package rootErrPkg;
  typedef enum logic [1:0] {
    SEV_COR      = 2'd0,
    SEV_NONFATAL = 2'd1,
    SEV_FATAL    = 2'd2,
    SEV_RSVD     = 2'd3
  } sevE;

  localparam int STS_W       = 7;
  localparam int CLS_W       = 3;
  localparam int B_COR       = 0;
  localparam int B_MULTICOR  = 1;
  localparam int B_UNCOR     = 2;
  localparam int B_MULTIUNC  = 3;
  localparam int B_FIRSTFAT  = 4;
  localparam int B_NONFATAL  = 5;
  localparam int B_FATAL     = 6;

  typedef struct packed {
    logic setCor;
    logic setMultiCor;
    logic capCorSrc;
    logic setUncor;
    logic setMultiUncor;
    logic capUncorSrc;
    logic setFirstFatal;
    logic setNonFatal;
    logic setFatal;
    logic fireMsi;
  } strobeT;

  function automatic logic [CLS_W-1:0] classOf(input logic [STS_W-1:0] s);
    return {s[B_FATAL], s[B_NONFATAL], s[B_COR]};
  endfunction
endpackage

// File: rtl/rootErrCtrl.sv
module rootErrCtrl
  import rootErrPkg::*;
(
  input  logic             msgValid,
  input  logic [1:0]       msgSev,
  input  logic [STS_W-1:0] sts,
  input  logic [CLS_W-1:0] cmd,
  input  logic             stsClrEn,
  input  logic [STS_W-1:0] stsClrData,
  input  logic             cmdWrEn,
  input  logic [CLS_W-1:0] cmdWrData,
  input  logic             msiEnable,
  output strobeT           strobe
);
  logic [STS_W-1:0] effSts;
  logic [STS_W-1:0] nextSts;
  logic [CLS_W-1:0] nextCmd;
  logic isCor, isNonFatal, isFatal, isUncor;
  logic condBefore, condAfter;

  always_comb begin
    effSts     = stsClrEn ? (sts & ~stsClrData) : sts;
    isCor      = msgValid && (sevE'(msgSev) == SEV_COR);
    isNonFatal = msgValid && (sevE'(msgSev) == SEV_NONFATAL);
    isFatal    = msgValid && (sevE'(msgSev) == SEV_FATAL);
    isUncor    = isNonFatal || isFatal;

    strobe               = '0;
    strobe.setCor        = isCor;
    strobe.setMultiCor   = isCor && effSts[B_COR];
    strobe.capCorSrc     = isCor && !effSts[B_COR];
    strobe.setUncor      = isUncor;
    strobe.setMultiUncor = isUncor && effSts[B_UNCOR];
    strobe.capUncorSrc   = isUncor && !effSts[B_UNCOR];
    strobe.setFirstFatal = isFatal && !effSts[B_UNCOR];
    strobe.setNonFatal   = isNonFatal;
    strobe.setFatal      = isFatal;

    nextSts = effSts;
    nextSts[B_COR]      = effSts[B_COR]      | strobe.setCor;
    nextSts[B_NONFATAL] = effSts[B_NONFATAL] | strobe.setNonFatal;
    nextSts[B_FATAL]    = effSts[B_FATAL]    | strobe.setFatal;
    nextCmd = cmdWrEn ? cmdWrData : cmd;

    condBefore = |(cmd & classOf(effSts));
    condAfter  = |(nextCmd & classOf(nextSts));
    strobe.fireMsi = msiEnable && condAfter && !condBefore;
  end
endmodule

// File: rtl/rootErrDatapath.sv
module rootErrDatapath
  import rootErrPkg::*;
#(
  parameter int SRC_W = 16,
  parameter int VEC_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobeT           strobe,
  input  logic [SRC_W-1:0] msgSrcId,
  input  logic             cmdWrEn,
  input  logic [CLS_W-1:0] cmdWrData,
  input  logic             stsClrEn,
  input  logic [STS_W-1:0] stsClrData,
  input  logic             msiEnable,
  input  logic             vecLoad,
  input  logic [VEC_W-1:0] vecIn,
  output logic [CLS_W-1:0] cmdReg,
  output logic [STS_W-1:0] stsReg,
  output logic [SRC_W-1:0] corSrcReg,
  output logic [SRC_W-1:0] uncorSrcReg,
  output logic [VEC_W-1:0] vecReg,
  output logic             intLevel,
  output logic             intPulse
);
  logic [STS_W-1:0] clrMask;
  logic [STS_W-1:0] setMask;

  always_comb begin
    clrMask = stsClrEn ? stsClrData : '0;
    setMask = '0;
    setMask[B_COR]      = strobe.setCor;
    setMask[B_MULTICOR] = strobe.setMultiCor;
    setMask[B_UNCOR]    = strobe.setUncor;
    setMask[B_MULTIUNC] = strobe.setMultiUncor;
    setMask[B_FIRSTFAT] = strobe.setFirstFatal;
    setMask[B_NONFATAL] = strobe.setNonFatal;
    setMask[B_FATAL]    = strobe.setFatal;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdReg      <= '0;
      stsReg      <= '0;
      corSrcReg   <= '0;
      uncorSrcReg <= '0;
      vecReg      <= '0;
      intPulse    <= 1'b0;
    end else begin
      stsReg   <= (stsReg & ~clrMask) | setMask;
      intPulse <= strobe.fireMsi;
      if (cmdWrEn)            cmdReg      <= cmdWrData;
      if (strobe.capCorSrc)   corSrcReg   <= msgSrcId;
      if (strobe.capUncorSrc) uncorSrcReg <= msgSrcId;
      if (vecLoad)            vecReg      <= vecIn;
    end
  end

  assign intLevel = !msiEnable && (|(cmdReg & classOf(stsReg)));

  // R1
  cor_src_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stsReg[B_COR] && !(stsClrEn && stsClrData[B_COR])) |=> $stable(corSrcReg));

  // R3
  uncor_src_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stsReg[B_UNCOR] && !(stsClrEn && stsClrData[B_UNCOR])) |=> $stable(uncorSrcReg));

  // R4
  pulse_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    intPulse |-> $past(msiEnable));

  // R8
  vec_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !vecLoad |=> $stable(vecReg));

  // R2
  first_fatal_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stsReg[B_FIRSTFAT]) |-> $past(strobe.setFatal));
endmodule

// File: rtl/root_err_collector.sv
module root_err_collector
  import rootErrPkg::*;
#(
  parameter int SRC_W = 16,
  parameter int VEC_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             msgValid,
  input  logic [1:0]       msgSev,
  input  logic [SRC_W-1:0] msgSrcId,
  input  logic             cmdWrEn,
  input  logic [2:0]       cmdWrData,
  input  logic             stsClrEn,
  input  logic [6:0]       stsClrData,
  input  logic             msiEnable,
  input  logic             vecLoad,
  input  logic [VEC_W-1:0] vecIn,
  output logic [2:0]       rootCmd,
  output logic [6:0]       rootSts,
  output logic [SRC_W-1:0] corSrcId,
  output logic [SRC_W-1:0] uncorSrcId,
  output logic [VEC_W-1:0] intVector,
  output logic             intLevel,
  output logic             intPulse
);
  strobeT strobe;

  rootErrCtrl u_ctrl (
    .msgValid   (msgValid),
    .msgSev     (msgSev),
    .sts        (rootSts),
    .cmd        (rootCmd),
    .stsClrEn   (stsClrEn),
    .stsClrData (stsClrData),
    .cmdWrEn    (cmdWrEn),
    .cmdWrData  (cmdWrData),
    .msiEnable  (msiEnable),
    .strobe     (strobe)
  );

  rootErrDatapath #(.SRC_W(SRC_W), .VEC_W(VEC_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .msgSrcId    (msgSrcId),
    .cmdWrEn     (cmdWrEn),
    .cmdWrData   (cmdWrData),
    .stsClrEn    (stsClrEn),
    .stsClrData  (stsClrData),
    .msiEnable   (msiEnable),
    .vecLoad     (vecLoad),
    .vecIn       (vecIn),
    .cmdReg      (rootCmd),
    .stsReg      (rootSts),
    .corSrcReg   (corSrcId),
    .uncorSrcReg (uncorSrcId),
    .vecReg      (intVector),
    .intLevel    (intLevel),
    .intPulse    (intPulse)
  );
endmodule

// File: tb/root_err_collector_tb.sv
module root_err_collector_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic msgValid = 1'b0;
  logic [1:0] msgSev = '0;
  logic [15:0] msgSrcId = '0;
  logic cmdWrEn = 1'b0;
  logic [2:0] cmdWrData = '0;
  logic stsClrEn = 1'b0;
  logic [6:0] stsClrData = '0;
  logic msiEnable = 1'b0;
  logic vecLoad = 1'b0;
  logic [4:0] vecIn = '0;
  logic [2:0] rootCmd;
  logic [6:0] rootSts;
  logic [15:0] corSrcId, uncorSrcId;
  logic [4:0] intVector;
  logic intLevel, intPulse;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    logic [6:0] sts;
    logic [2:0] cmd;
    logic [15:0] cor;
    logic [15:0] uncor;
    logic [4:0] vec;
    logic level;
    logic pulse;
  } expT;
  expT expQ[$];
  string tagQ[$];

  always #10 clk = ~clk;

  root_err_collector u_dut (
    .clk(clk), .rstN(rstN), .msgValid(msgValid), .msgSev(msgSev),
    .msgSrcId(msgSrcId), .cmdWrEn(cmdWrEn), .cmdWrData(cmdWrData),
    .stsClrEn(stsClrEn), .stsClrData(stsClrData), .msiEnable(msiEnable),
    .vecLoad(vecLoad), .vecIn(vecIn), .rootCmd(rootCmd), .rootSts(rootSts),
    .corSrcId(corSrcId), .uncorSrcId(uncorSrcId), .intVector(intVector),
    .intLevel(intLevel), .intPulse(intPulse)
  );

  task automatic cmpVal(string tag, string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // monitor: pops one expectation per clock, samples 5 ns after the edge
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (expQ.size() > 0) begin
        expT e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        cmpVal(t, "rootSts", 16'(rootSts), 16'(e.sts));
        cmpVal(t, "rootCmd", 16'(rootCmd), 16'(e.cmd));
        cmpVal(t, "corSrcId", corSrcId, e.cor);
        cmpVal(t, "uncorSrcId", uncorSrcId, e.uncor);
        cmpVal(t, "intVector", 16'(intVector), 16'(e.vec));
        cmpVal(t, "intLevel", 16'(intLevel), 16'(e.level));
        cmpVal(t, "intPulse", 16'(intPulse), 16'(e.pulse));
      end
    end
  end

  // driver: applies one cycle of stimulus and queues the post-edge expectation
  task automatic step(input logic mv, input logic [1:0] sev, input logic [15:0] src,
                      input logic cw, input logic [2:0] cd,
                      input logic ce, input logic [6:0] cl,
                      input logic msi, input logic vl, input logic [4:0] vi,
                      input logic [6:0] eSts, input logic [2:0] eCmd,
                      input logic [15:0] eCor, input logic [15:0] eUnc,
                      input logic [4:0] eVec, input logic eLvl, input logic ePls,
                      input string tag);
    expT e;
    @(negedge clk);
    msgValid = mv; msgSev = sev; msgSrcId = src;
    cmdWrEn = cw; cmdWrData = cd; stsClrEn = ce; stsClrData = cl;
    msiEnable = msi; vecLoad = vl; vecIn = vi;
    e.sts = eSts; e.cmd = eCmd; e.cor = eCor; e.uncor = eUnc;
    e.vec = eVec; e.level = eLvl; e.pulse = ePls;
    expQ.push_back(e);
    tagQ.push_back(tag);
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #5;
    cmpVal("R9", "reset rootSts", 16'(rootSts), 16'h0);
    cmpVal("R9", "reset rootCmd", 16'(rootCmd), 16'h0);
    cmpVal("R9", "reset intPulse", 16'(intPulse), 16'h0);
    @(negedge clk);
    rstN = 1'b1;

    // legacy mode
    step(0,0,16'h0,    1,3'b111, 0,7'h00, 0, 0,5'h0, 7'h00,3'd7,16'h0000,16'h0000,5'h00,0,0,"R5 cmd write");
    step(1,0,16'h1234, 0,3'b000, 0,7'h00, 0, 0,5'h0, 7'h01,3'd7,16'h1234,16'h0000,5'h00,1,0,"R1 R5 first cor");
    step(1,0,16'hBEEF, 0,3'b000, 0,7'h00, 0, 0,5'h0, 7'h03,3'd7,16'h1234,16'h0000,5'h00,1,0,"R1 repeat cor");
    step(1,1,16'h0A0A, 0,3'b000, 0,7'h00, 0, 0,5'h0, 7'h27,3'd7,16'h1234,16'h0A0A,5'h00,1,0,"R2 R3 nonfatal");
    step(1,2,16'h0F0F, 0,3'b000, 0,7'h00, 0, 0,5'h0, 7'h6F,3'd7,16'h1234,16'h0A0A,5'h00,1,0,"R2 R3 fatal after uncor");
    step(0,0,16'h0,    1,3'b000, 0,7'h00, 0, 0,5'h0, 7'h6F,3'd0,16'h1234,16'h0A0A,5'h00,0,0,"R5 cmd cleared");
    step(0,0,16'h0,    0,3'b000, 1,7'h7F, 0, 1,5'h15,7'h00,3'd0,16'h1234,16'h0A0A,5'h15,0,0,"R7 R8 clear all, load vec");
    step(1,2,16'h5555, 0,3'b000, 0,7'h00, 0, 0,5'h0, 7'h54,3'd0,16'h1234,16'h5555,5'h15,0,0,"R2 R3 first fatal");
    step(0,0,16'h0,    1,3'b100, 0,7'h00, 0, 0,5'h0, 7'h54,3'd4,16'h1234,16'h5555,5'h15,1,0,"R5 cmd enables fatal");
    step(1,3,16'h9999, 0,3'b000, 0,7'h00, 0, 0,5'h0, 7'h54,3'd4,16'h1234,16'h5555,5'h15,1,0,"R11 reserved sev");
    step(1,0,16'h7777, 0,3'b000, 1,7'h7F, 0, 0,5'h0, 7'h01,3'd4,16'h7777,16'h5555,5'h15,0,0,"R10 clear plus msg");
    step(0,0,16'h0,    0,3'b000, 1,7'h01, 0, 0,5'h0, 7'h00,3'd4,16'h7777,16'h5555,5'h15,0,0,"R7 partial clear");

    // message mode
    step(0,0,16'h0,    1,3'b000, 0,7'h00, 1, 0,5'h0, 7'h00,3'd0,16'h7777,16'h5555,5'h15,0,0,"R6 cmd zero");
    step(0,0,16'h0,    1,3'b001, 0,7'h00, 1, 0,5'h0, 7'h00,3'd1,16'h7777,16'h5555,5'h15,0,0,"R6 enable no status");
    step(1,1,16'h2222, 0,3'b000, 0,7'h00, 1, 0,5'h0, 7'h24,3'd1,16'h7777,16'h2222,5'h15,0,0,"R4 disabled class");
    step(1,0,16'h3333, 0,3'b000, 0,7'h00, 1, 0,5'h0, 7'h25,3'd1,16'h3333,16'h2222,5'h15,0,1,"R4 first enabled");
    step(1,0,16'h4444, 0,3'b000, 0,7'h00, 1, 0,5'h0, 7'h27,3'd1,16'h3333,16'h2222,5'h15,0,0,"R4 R1 already asserted");
    step(0,0,16'h0,    1,3'b011, 0,7'h00, 1, 0,5'h0, 7'h27,3'd3,16'h3333,16'h2222,5'h15,0,0,"R6 already true");
    step(0,0,16'h0,    1,3'b000, 0,7'h00, 1, 0,5'h0, 7'h27,3'd0,16'h3333,16'h2222,5'h15,0,0,"R6 disable all");
    step(0,0,16'h0,    1,3'b010, 0,7'h00, 1, 0,5'h0, 7'h27,3'd2,16'h3333,16'h2222,5'h15,0,1,"R6 R5 write makes true");
    step(0,0,16'h0,    0,3'b000, 0,7'h00, 1, 0,5'h0, 7'h27,3'd2,16'h3333,16'h2222,5'h15,0,0,"R6 single cycle pulse");
    step(0,0,16'h0,    1,3'b111, 0,7'h00, 0, 0,5'h0, 7'h27,3'd7,16'h3333,16'h2222,5'h15,1,0,"R5 back to legacy");

    @(negedge clk);
    msgValid = 0; cmdWrEn = 0; stsClrEn = 0; vecLoad = 0;
    wait (expQ.size() == 0);
    @(negedge clk);
    rstN = 1'b0;
    @(posedge clk);
    #5;
    cmpVal("R9", "mid reset rootCmd", 16'(rootCmd), 16'h0);
    cmpVal("R9", "mid reset rootSts", 16'(rootSts), 16'h0);
    cmpVal("R9", "mid reset intVector", 16'(intVector), 16'h0);
    cmpVal("R9", "mid reset corSrcId", corSrcId, 16'h0);
    @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(posedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule